// File: doc/BRIEF.md
# Dual-Edge Strobe Capture Synchronizer

This block brings words from an external device into a free-running system clock domain. The device marks each word with a transition of an intermittent strobe. Both the rising and the falling transition carry a word, and the strobe may stay at one level for any length of time. The strobe never clocks any register here. It is sampled as ordinary data by the system clock. It passes through a two-flop synchronizer and one more history register, and a transition shows up as a difference between the last two stages.

The data bus runs through a parallel delay line of the same depth as the strobe path. For every detected transition the block emits one system-clock-wide `cap_valid` pulse. On the same cycle it presents the delayed data word and a polarity tag. This output stream has no `ready`: there is no back-pressure. The consumer, typically a single-clock FIFO write port, must accept the word in every cycle where `cap_valid` is high. A 16-bit counter of delivered words lets the surrounding logic or a bench confirm that no transition was lost or duplicated.

The system clock must run at least four times faster than the fastest strobe transition rate. `cap_data` is taken from the value `din` had on the system clock edge just before the first edge that samples the new strobe level. The bus must therefore be stable for two system cycles ahead of a strobe transition.

Top module: `dual_edge_capture`

## Requirements
- R1: While `rst` is high (synchronous, active high), `cap_valid`, `cap_rise`, `cap_data` and `word_count` are cleared on the next clock edge. With `strb` at the idle level (parameter `IDLE_LVL`, default 1), reset release produces no `cap_valid` pulse.
- R2: A low-to-high transition of `strb` produces exactly one `cap_valid` cycle with `cap_rise` = 1.
- R3: A high-to-low transition of `strb` produces exactly one `cap_valid` cycle with `cap_rise` = 0.
- R4: Count the first rising clock edge that samples the new strobe level as edge 1. `cap_valid` is high after edge 3 and low after edges 1, 2 and 4.
- R5: `cap_data` during the `cap_valid` cycle equals the `din` value sampled on the clock edge just before edge 1 of R4.
- R6: A strobe held at a constant level for any number of cycles, including a word written at the level the strobe already has, produces no `cap_valid` pulse.
- R7: `word_count` rises by exactly one on the clock edge after each `cap_valid` cycle and holds otherwise.
- R8: Two strobe transitions two system cycles apart each produce their own `cap_valid` pulse, two cycles apart.
- R9: A reset in the middle of traffic, with `strb` at the idle level, returns `word_count` to 0, and later transitions count from there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous reset, active high |
| strb | input | 1 | Asynchronous dual-edge strobe from the device |
| din | input | DATA_W | Device data bus, asynchronous |
| cap_valid | output | 1 | One-cycle pulse per detected strobe transition; no back-pressure |
| cap_data | output | DATA_W | Captured word, valid while `cap_valid` is high |
| cap_rise | output | 1 | Polarity of the transition: 1 rising, 0 falling |
| word_count | output | CNT_W | Count of delivered words, cleared by reset |

## Verification
The hardest case to reach from the ports is two transitions at the minimum spacing. In that case the synchronizer holds a second transition while the first is still being flagged. The directed stimulus toggles `strb` twice, two cycles apart, at falling clock edges. It then expects two pulses exactly two cycles apart and a count step of two. The vector table also repeats the current strobe level with a new data word, which shows that a write without a transition leaves both the pulse and the count untouched.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int unsigned CNT_W_DEF = 16;
  typedef enum logic {
    POL_FALL = 1'b0,
    POL_RISE = 1'b1
  } edge_pol_t;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int unsigned STAGES   = 2,
  parameter logic        IDLE_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic strb_async,
  output logic lvl_new,
  output logic lvl_old
);
  logic [STAGES-1:0] chain;
  logic              hist;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= IDLE_LVL;
    else     chain[0] <= strb_async;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= IDLE_LVL;
      else     chain[i] <= chain[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) hist <= IDLE_LVL;
    else     hist <= chain[STAGES-1];
  end

  assign lvl_new = chain[STAGES-1];
  assign lvl_old = hist;

  // R1: the history stage comes out of reset at the idle level
  p_hist_idle_r1: assert property (@(posedge clk) rst |=> (hist == IDLE_LVL));
endmodule

// File: rtl/bus_delay.sv
module bus_delay #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] pipe [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= '0;
    else     pipe[0] <= d_in;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_pipe
    always_ff @(posedge clk) begin
      if (rst) pipe[i] <= '0;
      else     pipe[i] <= pipe[i-1];
    end
  end

  assign d_out = pipe[DEPTH-1];
endmodule

// File: rtl/edge_flag.sv
module edge_flag
  import cap_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lvl_new,
  input  logic             lvl_old,
  input  logic [WIDTH-1:0] word_in,
  output logic             pulse,
  output edge_pol_t        pol,
  output logic [WIDTH-1:0] word_out
);
  logic seen;
  assign seen = lvl_new ^ lvl_old;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse    <= 1'b0;
      pol      <= POL_FALL;
      word_out <= '0;
    end else begin
      pulse <= seen;
      if (seen) begin
        pol      <= edge_pol_t'(lvl_new);
        word_out <= word_in;
      end
    end
  end

  // R2 R3: polarity and data hold between pulses
  p_hold_between_r5: assert property (@(posedge clk) disable iff (rst)
    !seen |=> ($stable(word_out) && $stable(pol)));
endmodule

// File: rtl/word_counter.sv
module word_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bump,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (bump) count <= count + 1'b1;
  end

  p_count_step_r7: assert property (@(posedge clk) disable iff (rst)
    bump |=> (count == $past(count) + 1'b1));
  p_count_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !bump |=> $stable(count));
endmodule

// File: rtl/dual_edge_capture.sv
module dual_edge_capture
  import cap_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CNT_W       = CNT_W_DEF,
  parameter logic        IDLE_LVL    = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strb,
  input  logic [DATA_W-1:0] din,
  output logic              cap_valid,
  output logic [DATA_W-1:0] cap_data,
  output logic              cap_rise,
  output logic [CNT_W-1:0]  word_count
);
  localparam int unsigned PATH_DEPTH = SYNC_STAGES + 1;

  logic              s_new;
  logic              s_old;
  logic [DATA_W-1:0] bus_late;
  edge_pol_t         pol;

  strobe_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(IDLE_LVL)) u_sync (
    .clk(clk), .rst(rst), .strb_async(strb),
    .lvl_new(s_new), .lvl_old(s_old)
  );

  bus_delay #(.WIDTH(DATA_W), .DEPTH(PATH_DEPTH)) u_bus (
    .clk(clk), .rst(rst), .d_in(din), .d_out(bus_late)
  );

  edge_flag #(.WIDTH(DATA_W)) u_flag (
    .clk(clk), .rst(rst), .lvl_new(s_new), .lvl_old(s_old),
    .word_in(bus_late), .pulse(cap_valid), .pol(pol), .word_out(cap_data)
  );

  word_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .bump(cap_valid), .count(word_count)
  );

  assign cap_rise = (pol == POL_RISE);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!cap_valid && word_count == '0));
  // R2 R6: a pulse only follows a real change of the synchronized level
  p_pulse_on_change_r6: assert property (@(posedge clk) disable iff (rst)
    cap_valid |-> (s_old != $past(s_old)));
  // R2 R3: polarity tag matches the level the strobe settled at
  p_polarity_r3: assert property (@(posedge clk) disable iff (rst)
    cap_valid |-> (cap_rise == s_old));
endmodule

// File: tb/tb_dual_edge_capture.sv
module tb_dual_edge_capture;
  localparam int W = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          strb = 1'b1;
  logic [W-1:0]  din = '0;
  logic          cap_valid;
  logic [W-1:0]  cap_data;
  logic          cap_rise;
  logic [15:0]   word_count;

  int n_checks = 0;
  int n_errors = 0;
  int exp_cnt  = 0;

  always #5 clk = ~clk;

  dual_edge_capture dut (
    .clk(clk), .rst(rst), .strb(strb), .din(din),
    .cap_valid(cap_valid), .cap_data(cap_data),
    .cap_rise(cap_rise), .word_count(word_count)
  );

  // {strobe level, data word}
  localparam logic [W:0] VEC [10] = '{
    {1'b0, 16'h00A1}, {1'b1, 16'h5B12}, {1'b1, 16'hC3C3}, {1'b0, 16'hD4E0},
    {1'b0, 16'h0E05}, {1'b1, 16'hF00F}, {1'b0, 16'h0707}, {1'b1, 16'hFFFF},
    {1'b0, 16'h0000}, {1'b1, 16'h8001}
  };

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Present a word, then move the strobe; check pulse timing, data, polarity, count
  task automatic send(input logic lvl, input logic [W-1:0] word);
    logic changed;
    changed = (lvl != strb);
    din = word;
    @(negedge clk); @(negedge clk);
    strb = lvl;
    @(negedge clk);
    chk(cap_valid == 1'b0, "R4 no pulse after edge 1", cap_valid, 0);
    @(negedge clk);
    chk(cap_valid == 1'b0, "R4 no pulse after edge 2", cap_valid, 0);
    @(negedge clk);
    if (changed) begin
      chk(cap_valid == 1'b1, "R4 pulse after edge 3", cap_valid, 1);
      chk(cap_data == word, "R5 captured word", cap_data, word);
      if (lvl) chk(cap_rise == 1'b1, "R2 rising tag", cap_rise, 1);
      else     chk(cap_rise == 1'b0, "R3 falling tag", cap_rise, 0);
      exp_cnt++;
    end else begin
      chk(cap_valid == 1'b0, "R6 no pulse on held level", cap_valid, 0);
    end
    @(negedge clk);
    chk(cap_valid == 1'b0, "R2 single cycle pulse", cap_valid, 0);
    chk(word_count == 16'(exp_cnt), "R7 word count", word_count, exp_cnt);
  endtask

  initial begin
    #200000;
    n_errors++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk(cap_valid == 0 && word_count == 0 && cap_data == 0, "R1 reset state",
        word_count, 0);
    rst = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(cap_valid == 1'b0, "R1 no spurious pulse", cap_valid, 0);
    end
    chk(word_count == 0, "R1 count after release", word_count, 0);

    for (int i = 0; i < 10; i++) send(VEC[i][W], VEC[i][W-1:0]);

    // R6: long idle at high level
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (cap_valid) chk(1'b0, "R6 idle strobe pulsed", cap_valid, 0);
    end
    chk(word_count == 16'(exp_cnt), "R6 count after idle", word_count, exp_cnt);

    // R8: two transitions two cycles apart
    din = 16'h2222;
    @(negedge clk); @(negedge clk);
    strb = 1'b0;
    @(negedge clk);
    @(negedge clk);
    strb = 1'b1;
    @(negedge clk);
    chk(cap_valid == 1'b1 && cap_rise == 1'b0, "R8 first pulse", cap_valid, 1);
    @(negedge clk);
    chk(cap_valid == 1'b0, "R8 gap between pulses", cap_valid, 0);
    @(negedge clk);
    chk(cap_valid == 1'b1 && cap_rise == 1'b1, "R8 second pulse", cap_valid, 1);
    @(negedge clk);
    exp_cnt += 2;
    chk(word_count == 16'(exp_cnt), "R8 count step of two", word_count, exp_cnt);

    // R9: mid-run reset with strobe idle
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(word_count == 0 && cap_valid == 0, "R9 cleared by reset", word_count, 0);
    exp_cnt = 0;
    send(1'b0, 16'h1357);
    send(1'b1, 16'h2468);
    chk(word_count == 2, "R9 count restarts", word_count, 2);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule